// File: doc/BRIEF.md
# Floating-point subnormal trap predictor

This block looks at one floating-point operation before its result is rounded and decides how the exception logic must treat it. The possible outcomes are an "unfinished" trap, which hands the operation to software, an IEEE exception trap, or silent completion. It also returns the current-exception flags and a request to flush a subnormal result to a signed zero. The decision uses the operation class, the precision, the biased operand exponents, and the class flags of each operand (subnormal, zero, NaN, infinity). It also uses a non-standard-mode bit and a trap-enable mask.

The block forms a signed, pre-rounding result exponent. For add/subtract and double-to-single conversion this exponent comes from the datapath. For multiply it is the operand exponents added, minus the bias, plus one. For divide it is their difference plus the bias. This exponent is compared against windows that depend on the operation and the precision. Divide and square root predict inexact pessimistically, and divide also predicts underflow pessimistically. The decision is registered. It appears one cycle after the operation is accepted and stays in place until it is taken under a valid/ready handshake.

Top module: `fp_subnorm_trap_predict`

## Requirements
- R1: An operation is accepted when `in_valid` and `in_ready` are both high at a clock edge. Its decision shows on `out_valid` from that edge on and stays unchanged while `out_ready` is low. `in_ready` is high when the output register is empty or is being drained in the same cycle.
- R2: While `rst` is high, and right after it is released, `out_valid` is 0 and `in_ready` is 1.
- R3: Operation codes are 0 convert (not narrowing), 1 double-to-single convert, 2 square root, 3 add/subtract, 4 widening single-to-double multiply, 5 multiply and 6 divide. Codes 3 to 6 use both operands. The other codes use operand A only.
- R3 (continued): The result exponent E is `in_pre_exp` for codes 1 and 3. For code 5 it is expA+expB-bias+1, and for code 6 it is expA-expB+bias. The bias is 127 in single precision and 1023 in double. Code 1 always uses the single-precision window.
- R4: With non-standard mode off, no subnormal operand and no zero/NaN/infinity operand, codes 1, 3 and 5 give an unfinished trap (`out_trap`=2) when L < E < 1. L is -25 in single precision and -54 in double.
- R5: Under the same conditions, divide gives an unfinished trap when L < E <= 1.
- R6: With non-standard mode off, one or more subnormal operands always gives an unfinished trap for codes 0 to 4.
- R7: With non-standard mode off and exactly one subnormal operand, multiply and divide give an unfinished trap only when E > L and E is below the all-ones biased exponent (255 single, 2047 double).
- R8: With non-standard mode off, two subnormal operands always give an unfinished trap.
- R9: With non-standard mode on, no unfinished trap is raised. For codes 1, 3, 5 and 6, a result with E below the divide-aware upper bound of R4/R5 raises underflow and inexact, and raises a flush request when no trap is taken. `out_flush` is never 1 when non-standard mode is off.
- R10: `out_cexc` bits are [2] overflow, [1] underflow and [0] inexact. `in_trap_en` uses the same bit positions. An enabled, raised flag gives `out_trap`=1 with only that bit set, with priority overflow, then underflow, then inexact. With no trap, `out_trap`=0 and all raised flags are reported.
- R11: Divide and square root always raise inexact, unless an operand is zero, NaN or infinity. A zero/NaN/infinity operand suppresses all flags and the result-window trap.
- R12: With non-standard mode off and E <= L, codes 1, 3, 5 and 6 raise underflow and inexact rather than an unfinished trap.
- R13: For codes 1, 3, 5 and 6, E at or above the all-ones biased exponent raises overflow and inexact.
- R14: An unfinished trap reports `out_cexc`=0 and `out_flush`=0. A flush request only appears together with `out_trap`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Operation can be accepted |
| in_op | input | 3 | Operation code (R3) |
| in_dbl | input | 1 | 1 = double precision |
| in_exp_a | input | 11 | Biased exponent of operand A |
| in_exp_b | input | 11 | Biased exponent of operand B |
| in_pre_exp | input | 14 | Signed pre-rounding biased exponent from the datapath (codes 1, 3) |
| in_cls_a | input | 4 | Operand A class: [3] subnormal, [2] zero, [1] NaN, [0] infinity |
| in_cls_b | input | 4 | Operand B class, same layout |
| in_ns | input | 1 | Non-standard (flush-to-zero) mode |
| in_trap_en | input | 3 | Trap enables: [2] overflow, [1] underflow, [0] inexact |
| out_valid | output | 1 | Decision present |
| out_ready | input | 1 | Decision taken |
| out_trap | output | 2 | 0 none, 1 IEEE trap, 2 unfinished trap |
| out_cexc | output | 3 | Current exceptions: [2] overflow, [1] underflow, [0] inexact |
| out_flush | output | 1 | Replace subnormal result by signed zero |

## Verification
The exponent windows are tested on both sides of each bound: just inside and just outside the lower bound in both precisions, and at E = 1 for add and divide. These cases show the exclusive bound of add apart from the inclusive bound of divide. The double-to-single case uses an exponent that lies inside the double window but outside the single window, which shows that the narrowing conversion uses the single window. Subnormal-operand patterns cover one versus two subnormals on every operation class, and single-subnormal multiply and divide are driven into overflow and deep underflow. Mask patterns in non-standard and standard mode, special operands, and output back-pressure check flag selection, trap priority and how long the output is held.

// File: rtl/fpst_pkg.sv
package fpst_pkg;

    localparam int SP_FRAC_W = 23;
    localparam int DP_FRAC_W = 52;
    localparam int SP_EXP_W  = 8;
    localparam int DP_EXP_W  = 11;
    localparam int EXP_W     = DP_EXP_W;
    localparam int ER_W      = EXP_W + 3;
    localparam int CLS_W     = 4;
    localparam int EXC_W     = 3;

    typedef enum logic [2:0] {
        FOP_CONV    = 3'd0,
        FOP_CONV_DS = 3'd1,
        FOP_SQRT    = 3'd2,
        FOP_ADDSUB  = 3'd3,
        FOP_MULW    = 3'd4,
        FOP_MUL     = 3'd5,
        FOP_DIV     = 3'd6
    } fop_e;

    typedef enum logic [1:0] {
        TRAP_NONE  = 2'd0,
        TRAP_IEEE  = 2'd1,
        TRAP_UNFIN = 2'd2
    } trap_e;

    typedef struct packed {
        logic sub;
        logic zero;
        logic nan;
        logic inf;
    } opnd_cls_t;

    typedef struct packed {
        logic of;
        logic uf;
        logic nx;
    } exc_t;

    typedef logic signed [ER_W-1:0] er_t;

    typedef struct packed {
        trap_e trap;
        exc_t  cexc;
        logic  flush;
    } resp_t;

    localparam int RESP_W = $bits(resp_t);

    function automatic logic uses_b(fop_e op);
        return (op == FOP_ADDSUB) || (op == FOP_MULW) ||
               (op == FOP_MUL)    || (op == FOP_DIV);
    endfunction

    function automatic er_t bias_of(logic dbl);
        return dbl ? er_t'((1 << (DP_EXP_W - 1)) - 1)
                   : er_t'((1 << (SP_EXP_W - 1)) - 1);
    endfunction

    function automatic er_t low_bound(logic dbl);
        return dbl ? er_t'(-(DP_FRAC_W + 2)) : er_t'(-(SP_FRAC_W + 2));
    endfunction

    function automatic er_t top_exp(logic dbl);
        return dbl ? er_t'((1 << DP_EXP_W) - 1) : er_t'((1 << SP_EXP_W) - 1);
    endfunction

endpackage

// File: rtl/fpst_exp_calc.sv
module fpst_exp_calc
    import fpst_pkg::*;
(
    input  fop_e             op,
    input  logic             dbl,
    input  logic [EXP_W-1:0] exp_a,
    input  logic [EXP_W-1:0] exp_b,
    input  er_t              pre_exp,
    output er_t              er,
    output logic             eff_dbl
);
    localparam int PAD_W = ER_W - EXP_W;

    er_t ext_a, ext_b, bias;

    always_comb begin
        eff_dbl = (op == FOP_CONV_DS) ? 1'b0 : dbl;
        ext_a   = $signed({{PAD_W{1'b0}}, exp_a});
        ext_b   = $signed({{PAD_W{1'b0}}, exp_b});
        bias    = bias_of(eff_dbl);
        case (op)
            FOP_MUL, FOP_MULW: er = ext_a + ext_b - bias + er_t'(1);
            FOP_DIV:           er = ext_a - ext_b + bias;
            default:           er = pre_exp;
        endcase
    end
endmodule

// File: rtl/fpst_decide.sv
module fpst_decide
    import fpst_pkg::*;
(
    input  fop_e      op,
    input  logic      eff_dbl,
    input  er_t       er,
    input  opnd_cls_t cls_a,
    input  opnd_cls_t cls_b,
    input  logic      ns,
    input  exc_t      trap_en,
    output resp_t     resp
);
    logic       two_src, special, tiny, huge, above_low, win_op;
    logic [1:0] n_sub;
    logic       unf_sub, unf_win, unfin;
    exc_t       raw;

    always_comb begin
        two_src   = uses_b(op);
        n_sub     = {1'b0, cls_a.sub} + {1'b0, two_src & cls_b.sub};
        special   = cls_a.zero | cls_a.nan | cls_a.inf |
                    (two_src & (cls_b.zero | cls_b.nan | cls_b.inf));
        win_op    = (op == FOP_CONV_DS) || (op == FOP_ADDSUB) ||
                    (op == FOP_MUL)     || (op == FOP_DIV);
        tiny      = (op == FOP_DIV) ? (er <= er_t'(1)) : (er < er_t'(1));
        huge      = er >= top_exp(eff_dbl);
        above_low = er > low_bound(eff_dbl);
    end

    // unfinished-trap prediction (standard mode only)
    always_comb begin
        unf_sub = 1'b0;
        case (op)
            FOP_CONV, FOP_CONV_DS, FOP_SQRT, FOP_ADDSUB, FOP_MULW:
                unf_sub = (n_sub != 2'd0);
            FOP_MUL, FOP_DIV:
                unf_sub = (n_sub == 2'd2) ||
                          ((n_sub == 2'd1) && !huge && above_low);
            default:
                unf_sub = 1'b0;
        endcase
        unf_win = (n_sub == 2'd0) && !special && win_op && tiny && above_low;
        unfin   = !ns && (unf_sub || unf_win);
    end

    // raw IEEE flags, pessimistic for divide / square root
    always_comb begin
        raw = '0;
        if (!unfin && !special) begin
            raw.of = win_op && huge;
            raw.uf = win_op && tiny;
            raw.nx = raw.of || raw.uf || (op == FOP_DIV) || (op == FOP_SQRT);
        end
    end

    // masking and priority: unfinished > IEEE trap > flush
    always_comb begin
        resp = '{trap: TRAP_NONE, cexc: '0, flush: 1'b0};
        if (unfin) begin
            resp.trap = TRAP_UNFIN;
        end else if (raw.of && trap_en.of) begin
            resp.trap    = TRAP_IEEE;
            resp.cexc.of = 1'b1;
        end else if (raw.uf && trap_en.uf) begin
            resp.trap    = TRAP_IEEE;
            resp.cexc.uf = 1'b1;
        end else if (raw.nx && trap_en.nx) begin
            resp.trap    = TRAP_IEEE;
            resp.cexc.nx = 1'b1;
        end else begin
            resp.cexc  = raw;
            resp.flush = ns && raw.uf;
        end
    end
endmodule

// File: rtl/fpst_out_stage.sv
module fpst_out_stage #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         up_valid,
    output logic         up_ready,
    input  logic [W-1:0] up_data,
    output logic         dn_valid,
    input  logic         dn_ready,
    output logic [W-1:0] dn_data
);
    assign up_ready = !dn_valid || dn_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            dn_valid <= 1'b0;
            dn_data  <= '0;
        end else if (up_valid && up_ready) begin
            dn_valid <= 1'b1;
            dn_data  <= up_data;
        end else if (dn_ready) begin
            dn_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/fp_subnorm_trap_predict.sv
module fp_subnorm_trap_predict
    import fpst_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [2:0]              in_op,
    input  logic                    in_dbl,
    input  logic [EXP_W-1:0]        in_exp_a,
    input  logic [EXP_W-1:0]        in_exp_b,
    input  logic signed [ER_W-1:0]  in_pre_exp,
    input  logic [CLS_W-1:0]        in_cls_a,
    input  logic [CLS_W-1:0]        in_cls_b,
    input  logic                    in_ns,
    input  logic [EXC_W-1:0]        in_trap_en,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [1:0]              out_trap,
    output logic [EXC_W-1:0]        out_cexc,
    output logic                    out_flush
);
    fop_e  op;
    er_t   er;
    logic  eff_dbl;
    resp_t next_resp, held_resp;

    assign op = fop_e'(in_op);

    fpst_exp_calc u_exp (
        .op      (op),
        .dbl     (in_dbl),
        .exp_a   (in_exp_a),
        .exp_b   (in_exp_b),
        .pre_exp (in_pre_exp),
        .er      (er),
        .eff_dbl (eff_dbl)
    );

    fpst_decide u_dec (
        .op      (op),
        .eff_dbl (eff_dbl),
        .er      (er),
        .cls_a   (opnd_cls_t'(in_cls_a)),
        .cls_b   (opnd_cls_t'(in_cls_b)),
        .ns      (in_ns),
        .trap_en (exc_t'(in_trap_en)),
        .resp    (next_resp)
    );

    fpst_out_stage #(.W(RESP_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .up_valid (in_valid),
        .up_ready (in_ready),
        .up_data  (next_resp),
        .dn_valid (out_valid),
        .dn_ready (out_ready),
        .dn_data  (held_resp)
    );

    assign out_trap  = held_resp.trap;
    assign out_cexc  = held_resp.cexc;
    assign out_flush = held_resp.flush;
endmodule

// File: rtl/fpst_chk.sv
module fpst_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic       in_ns,
    input logic       out_valid,
    input logic       out_ready,
    input logic [1:0] out_trap,
    input logic [2:0] out_cexc,
    input logic       out_flush
);
    assert_reset_empty_R2: assert property (@(posedge clk)
        rst |=> !out_valid);

    assert_accept_latency_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid);

    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_trap) &&
                                    $stable(out_cexc) && $stable(out_flush));

    assert_ns_no_unfin_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_ns |=> out_trap != 2'd2);

    assert_std_no_flush_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && !in_ns |=> !out_flush);

    assert_single_trap_bit_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_trap == 2'd1 |-> $countones(out_cexc) == 1);

    assert_unfin_clean_R14: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_trap == 2'd2 |-> out_cexc == 3'd0 && !out_flush);

    assert_flush_quiet_R14: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_flush |-> out_trap == 2'd0);
endmodule

bind fp_subnorm_trap_predict fpst_chk chk_i (.*);

// File: tb/fp_subnorm_trap_predict_tb_top.sv
`timescale 1ns/10ps
module fp_subnorm_trap_predict_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_op = '0;
    logic        in_dbl = 1'b0;
    logic [10:0] in_exp_a = '0, in_exp_b = '0;
    logic signed [13:0] in_pre_exp = '0;
    logic [3:0]  in_cls_a = '0, in_cls_b = '0;
    logic        in_ns = 1'b0;
    logic [2:0]  in_trap_en = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [1:0]  out_trap;
    logic [2:0]  out_cexc;
    logic        out_flush;

    int checks = 0, fails = 0;
    int cyc = 0;
    bit stall = 1'b0;
    bit finished = 1'b0;
    logic [5:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fp_subnorm_trap_predict dut_i (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // expected {trap[1:0], cexc[2:0], flush} from the requirements
    function automatic logic [5:0] model(int op, int dbl, int ea, int eb, int pre,
                                         logic [3:0] ca, logic [3:0] cb,
                                         int ns, logic [2:0] en);
        int d, bias, lo, mx, er, nsub;
        bit two, spec, tiny, win, unf, of, uf, nx;
        logic [1:0] trap;
        logic [2:0] cx;
        bit fl;
        d    = (op == 1) ? 0 : dbl;
        bias = d ? 1023 : 127;
        lo   = d ? -54 : -25;
        mx   = d ? 2047 : 255;
        if (op == 4 || op == 5)      er = ea + eb - bias + 1;
        else if (op == 6)            er = ea - eb + bias;
        else                         er = pre;
        two  = (op >= 3);
        nsub = int'(ca[3]) + ((two && cb[3]) ? 1 : 0);
        spec = (|ca[2:0]) || (two && (|cb[2:0]));
        tiny = (op == 6) ? (er <= 1) : (er < 1);
        win  = (op == 1 || op == 3 || op == 5 || op == 6);
        unf  = 1'b0;
        if (ns == 0) begin
            if (nsub >= 1 && op <= 4) unf = 1'b1;
            if (nsub == 2) unf = 1'b1;
            if (nsub == 1 && (op == 5 || op == 6) && er < mx && er > lo) unf = 1'b1;
            if (nsub == 0 && !spec && win && tiny && er > lo) unf = 1'b1;
        end
        of = 0; uf = 0; nx = 0;
        if (!unf && !spec) begin
            of = win && (er >= mx);
            uf = win && tiny;
            nx = of || uf || op == 2 || op == 6;
        end
        fl = 1'b0;
        if (unf)                 begin trap = 2; cx = 3'b000; end
        else if (of && en[2])    begin trap = 1; cx = 3'b100; end
        else if (uf && en[1])    begin trap = 1; cx = 3'b010; end
        else if (nx && en[0])    begin trap = 1; cx = 3'b001; end
        else begin trap = 0; cx = {of, uf, nx}; fl = (ns != 0) && uf; end
        return {trap, cx, fl};
    endfunction

    task automatic send(input int op, input int dbl, input int ea, input int eb,
                        input int pre, input logic [3:0] ca, input logic [3:0] cb,
                        input int ns, input logic [2:0] en, input string tag);
        @(negedge clk);
        #0.5;
        in_op = op[2:0]; in_dbl = dbl[0];
        in_exp_a = ea[10:0]; in_exp_b = eb[10:0];
        in_pre_exp = pre[13:0];
        in_cls_a = ca; in_cls_b = cb; in_ns = ns[0]; in_trap_en = en;
        in_valid = 1'b1;
        #0.5;
        while (!in_ready) begin
            @(negedge clk);
            #1.0;
        end
        exp_q.push_back(model(op, dbl, ea, eb, pre, ca, cb, ns, en));
        tag_q.push_back(tag);
        @(posedge clk);
        #0.5;
        in_valid = 1'b0;
    endtask

    // monitor / scoreboard
    initial begin
        bit         was_held;
        logic [5:0] held;
        was_held = 1'b0;
        held = '0;
        forever begin
            @(negedge clk);
            out_ready = stall ? (cyc % 3 != 0) : 1'b1;
            #1.5;
            if (!rst) begin
                if (was_held) begin
                    check(out_valid && {out_trap, out_cexc, out_flush} == held,
                          "R1", "held output",
                          {out_valid, out_trap, out_cexc, out_flush}, {1'b1, held});
                end
                was_held = 1'b0;
                if (out_valid) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R1", "unexpected output", 1, 0);
                    end else if (out_ready) begin
                        logic [5:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check({out_trap, out_cexc, out_flush} == e, t, "decision",
                              {out_trap, out_cexc, out_flush}, e);
                    end else begin
                        was_held = 1'b1;
                        held = {out_trap, out_cexc, out_flush};
                    end
                end
            end
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "WD", "watchdog expired", 0, 1);
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        #2.0;
        check(!out_valid && in_ready, "R2", "during reset", {out_valid, in_ready}, 2'b01);
        rst = 1'b0;
        @(negedge clk);
        #2.0;
        check(!out_valid && in_ready, "R2", "after reset", {out_valid, in_ready}, 2'b01);

        // R1 latency: one cycle
        send(3, 0, 0, 0, 0, 4'h0, 4'h0, 0, 3'b000, "R4 add sp E=0");
        @(negedge clk);
        #1.0;
        check(out_valid, "R1", "valid one cycle after accept", out_valid, 1);

        // R4 / R12 windows
        send(3, 0, 0, 0, 1,   4'h0, 4'h0, 0, 3'b000, "R4 add sp E=1");
        send(3, 0, 0, 0, -24, 4'h0, 4'h0, 0, 3'b000, "R4 add sp E=-24");
        send(3, 0, 0, 0, -25, 4'h0, 4'h0, 0, 3'b000, "R12 add sp E=-25");
        send(3, 1, 0, 0, -53, 4'h0, 4'h0, 0, 3'b000, "R4 add dp E=-53");
        send(3, 1, 0, 0, -54, 4'h0, 4'h0, 0, 3'b000, "R12 add dp E=-54");
        send(3, 1, 0, 0, -30, 4'h0, 4'h0, 0, 3'b000, "R4 add dp E=-30");
        // R3 multiply / divide exponent
        send(5, 0, 63, 63, 0,  4'h0, 4'h0, 0, 3'b000, "R3 mul sp E=0");
        send(5, 0, 64, 63, 0,  4'h0, 4'h0, 0, 3'b000, "R3 mul sp E=1");
        send(5, 1, 500, 500, 0, 4'h0, 4'h0, 0, 3'b000, "R3 mul dp E=-22");
        // R5 divide inclusive bound, R11 pessimistic inexact
        send(6, 0, 127, 253, 0, 4'h0, 4'h0, 0, 3'b000, "R5 div sp E=1");
        send(6, 0, 128, 253, 0, 4'h0, 4'h0, 0, 3'b000, "R11 div sp E=2");
        send(6, 1, 0, 1100, 0, 4'h0, 4'h0, 0, 3'b000, "R12 div dp E=-77");
        // double-to-single uses single window
        send(1, 1, 0, 0, 0,   4'h0, 4'h0, 0, 3'b000, "R4 cvt ds E=0");
        send(1, 1, 0, 0, -30, 4'h0, 4'h0, 0, 3'b000, "R12 cvt ds E=-30");
        // R6 single subnormal operand
        send(2, 0, 0, 0, 0, 4'h8, 4'h0, 0, 3'b000, "R6 sqrt sub");
        send(0, 1, 0, 0, 0, 4'h8, 4'h0, 0, 3'b000, "R6 conv sub");
        send(4, 0, 0, 100, 0, 4'h8, 4'h0, 0, 3'b000, "R6 mulw sub");
        send(3, 0, 0, 0, 50, 4'h0, 4'h8, 0, 3'b000, "R6 add sub b");
        send(0, 0, 0, 0, 0, 4'h0, 4'h8, 0, 3'b000, "R3 conv ignores b");
        // R7 one subnormal multiply / divide
        send(5, 0, 0, 127, 0, 4'h8, 4'h0, 0, 3'b000, "R7 mul sub E=1");
        send(5, 0, 0, 100, 0, 4'h8, 4'h0, 0, 3'b000, "R7 mul sub E=-26");
        send(6, 0, 254, 0, 0, 4'h0, 4'h8, 0, 3'b000, "R7 div sub overflow");
        send(6, 1, 0, 0, 0, 4'h0, 4'h8, 0, 3'b000, "R7 div dp sub E=1023");
        // R8 two subnormals
        send(5, 0, 0, 0, 0, 4'h8, 4'h8, 0, 3'b000, "R8 mul two sub");
        send(6, 1, 0, 0, 0, 4'h8, 4'h8, 0, 3'b000, "R8 div two sub");
        // R9 / R10 non-standard mode
        send(3, 0, 0, 0, 0, 4'h0, 4'h0, 1, 3'b000, "R9 ns add flush");
        send(3, 0, 0, 0, 0, 4'h0, 4'h0, 1, 3'b010, "R10 ns uf trap");
        send(3, 0, 0, 0, 0, 4'h0, 4'h0, 1, 3'b001, "R10 ns nx trap");
        send(3, 0, 0, 0, 0, 4'h0, 4'h0, 1, 3'b011, "R10 ns uf over nx");
        send(2, 0, 0, 0, 0, 4'h8, 4'h0, 1, 3'b000, "R9 ns sqrt sub");
        send(6, 0, 127, 253, 0, 4'h0, 4'h0, 1, 3'b000, "R9 ns div E=1");
        // R13 overflow and mask priority
        send(5, 0, 200, 200, 0, 4'h0, 4'h0, 0, 3'b000, "R13 mul sp ovf");
        send(5, 0, 200, 200, 0, 4'h0, 4'h0, 0, 3'b111, "R10 ovf first");
        send(5, 0, 200, 200, 0, 4'h0, 4'h0, 0, 3'b011, "R10 nx when ovf off");
        send(3, 0, 0, 0, 255, 4'h0, 4'h0, 0, 3'b000, "R13 add sp E=255");
        send(3, 0, 0, 0, 254, 4'h0, 4'h0, 0, 3'b000, "R13 add sp E=254");
        // R11 special operands
        send(6, 0, 128, 0, 0, 4'h0, 4'h4, 0, 3'b111, "R11 div by zero op");
        send(2, 1, 0, 0, 0, 4'h1, 4'h0, 0, 3'b111, "R11 sqrt inf");
        send(3, 0, 0, 0, 0, 4'h0, 4'h2, 0, 3'b000, "R11 add nan in window");
        send(4, 0, 100, 100, 0, 4'h0, 4'h0, 0, 3'b111, "R3 mulw normal");
        // R14 priority
        send(3, 0, 0, 0, 0, 4'h0, 4'h0, 0, 3'b111, "R14 unfin over ieee");

        // R1 back-pressure
        stall = 1'b1;
        for (int k = 0; k < 12; k++) begin
            send(3, k % 2, 0, 0, -k * 3, 4'h0, 4'h0, k % 2, 3'(k), "R1 stall stream");
        end
        send(6, 0, 127, 253, 0, 4'h0, 4'h0, 0, 3'b000, "R1 stall div");
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        stall = 1'b0;
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule